// File: doc/BRIEF.md
# Spike-Driven Thermometer Weight Controller

This block converts a stream of spike events into a growing set of compliance enable lines for a memristive synapse cell. A thermometer-coded stage register advances one step per detected spike. With each step one more enable is switched on, so the compliance current allowed through the cell rises and the cell's conductance steps up. The register has one stage more than there are enables. That extra top stage is never exported as an enable. When a spike fills it, the controller clears the whole register on the following clock and emits a one-cycle request for an external cell RESET pulse.

The spike input is asynchronous. It is synchronised with two flops, and only its rising edge counts, so one spike of any length advances the register exactly once. A parallel load port writes a whole enable pattern in one step, so the weights can be set before learning starts. A mode input selects between two directions. In increment mode each spike adds an enable. In decrement mode each spike removes the highest active enable. The complement of every enable is also driven out, for cells wired to lower conductance when an enable is active.

Top module: `spike_thermo_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, all stages clear. After that edge `enable` is all zeros, `enableN` is all ones and `cellResetReq` is 0.
- R2: `spikeIn` passes through two synchroniser flops, and only a 0-to-1 transition counts as one event. A spike first sampled high at clock edge k acts on the register at edge k+2. A spike held high for many cycles produces only one event.
- R3: In increment mode (`decMode` = 0) each event sets the lowest stage that is still clear. `enable[0]` turns on first, then `enable[1]`, and so on upward.
- R4: An event that sets the top stage (the `STAGES`-th step counted from empty) leaves `enable` all ones for one cycle. At the next edge every stage clears, and `cellResetReq` is high for exactly one cycle after that edge.
- R5: `enableN` is always the bitwise complement of `enable`.
- R6: When `loadEn` is high at an edge, the register is written from `loadValue`. Only the unbroken run of ones starting at `loadValue[0]` is kept, and the top stage is cleared. Example with 4 enables: a value of 4'b1011 yields `enable` = 4'b0011.
- R7: Priority at an edge, from highest to lowest: reset, then the auto-clear of a full register, then a parallel load, then a spike event. An event in the same cycle as a load or a clear is dropped.
- R8: In decrement mode (`decMode` = 1) each event clears the highest set enable. With all enables clear, an event changes nothing and raises no `cellResetReq`.
- R9: `enable` is always a valid thermometer code: no set bit lies above a clear bit.
- R10: The number of stages is the parameter `STAGES`. Both `enable` and `enableN` are `STAGES-1` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spikeIn | input | 1 | Asynchronous spike input |
| decMode | input | 1 | 0 = each event adds an enable, 1 = each event removes one |
| loadEn | input | 1 | Parallel load strobe |
| loadValue | input | STAGES-1 | Pattern written on a load |
| enable | output | STAGES-1 | Compliance enables, thermometer coded |
| enableN | output | STAGES-1 | Complement of `enable` |
| cellResetReq | output | 1 | One-cycle request for a cell RESET pulse |

## Verification
The bench builds the block with `STAGES` = 5, which gives four enables and one wrap detector. A full increment run to the wrap, the auto-clear and the reset request therefore fit in a few hundred cycles. At this width every load pattern that matters can be written by hand: broken runs, all ones and all zeros. The bench times spikes from the known two-flop latency, so that an event can be placed on the same edge as a load, and a reset can be placed on the same edge as a load.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef struct packed {
    logic clearAll;
    logic loadNow;
    logic shiftUp;
    logic shiftDown;
  } stcStrobes_t;
endpackage

// File: rtl/stc_spike_sync.sv
module stc_spike_sync #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic spikeIn,
  output logic eventPulse
);
  logic [SYNC_DEPTH-1:0] syncQ;
  logic prevQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_DEPTH-2:0], spikeIn};
      prevQ <= syncQ[SYNC_DEPTH-1];
    end
  end

  assign eventPulse = syncQ[SYNC_DEPTH-1] & ~prevQ;

  // R2: one event per rising edge, never two in a row
  a_r2_single_event: assert property (@(posedge clk) disable iff (rst)
    eventPulse |=> !eventPulse);
endmodule

// File: rtl/stc_control.sv
module stc_control
  import stc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        eventPulse,
  input  logic        loadEn,
  input  logic        decMode,
  input  logic        topStage,
  output stcStrobes_t strobes,
  output logic        cellResetReq
);
  always_comb begin
    strobes = '0;
    if (topStage)           strobes.clearAll  = 1'b1;
    else if (loadEn)        strobes.loadNow   = 1'b1;
    else if (eventPulse)  begin
      if (decMode)          strobes.shiftDown = 1'b1;
      else                  strobes.shiftUp   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cellResetReq <= 1'b0;
    else     cellResetReq <= topStage;
  end

  // R4: the request is a single-cycle pulse
  a_r4_req_single: assert property (@(posedge clk) disable iff (rst)
    cellResetReq |=> !cellResetReq);
  // R4: a full register always produces a request
  a_r4_req_follows_top: assert property (@(posedge clk) disable iff (rst)
    topStage |=> cellResetReq);
endmodule

// File: rtl/stc_datapath.sv
module stc_datapath
  import stc_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int EN_W  = STAGES - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  stcStrobes_t     strobes,
  input  logic [EN_W-1:0] loadValue,
  output logic [EN_W-1:0] enable,
  output logic            topStage
);
  logic [STAGES-1:0] stageQ;
  logic [STAGES-1:0] stageD;
  logic [EN_W-1:0]   cleanLoad;

  // keep only the unbroken run of ones from bit 0
  assign cleanLoad[0] = loadValue[0];
  for (genvar i = 1; i < EN_W; i++) begin : g_clean
    assign cleanLoad[i] = loadValue[i] & cleanLoad[i-1];
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic fromBelow, fromAbove, fromLoad;
    if (i == 0) begin : g_bot
      assign fromBelow = 1'b1;
    end else begin : g_mid
      assign fromBelow = stageQ[i-1];
    end
    if (i == STAGES - 1) begin : g_top
      assign fromAbove = 1'b0;
      assign fromLoad  = 1'b0;
    end else begin : g_low
      assign fromAbove = stageQ[i+1];
      assign fromLoad  = cleanLoad[i];
    end
    always_comb begin
      if (strobes.clearAll)       stageD[i] = 1'b0;
      else if (strobes.loadNow)   stageD[i] = fromLoad;
      else if (strobes.shiftUp)   stageD[i] = fromBelow;
      else if (strobes.shiftDown) stageD[i] = fromAbove;
      else                        stageD[i] = stageQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stageQ <= '0;
    else     stageQ <= stageD;
  end

  assign enable   = stageQ[EN_W-1:0];
  assign topStage = stageQ[STAGES-1];

  // R9: stage register stays thermometer coded
  a_r9_thermo: assert property (@(posedge clk) disable iff (rst)
    (stageQ & (stageQ + 1'b1)) == '0);
  // R3: an upward shift adds exactly one stage
  a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
    strobes.shiftUp |=> $countones(stageQ) == $countones($past(stageQ)) + 1);
  // R8: a downward shift on a non-empty register removes exactly one stage
  a_r8_step_down: assert property (@(posedge clk) disable iff (rst)
    (strobes.shiftDown && stageQ != '0) |=> $countones(stageQ) == $countones($past(stageQ)) - 1);
  // R4: a full register is empty one edge later
  a_r4_auto_clear: assert property (@(posedge clk) disable iff (rst)
    topStage |=> stageQ == '0);
  // R6: a load never sets the top stage
  a_r6_load_top_clear: assert property (@(posedge clk) disable iff (rst)
    strobes.loadNow |=> !topStage);
endmodule

// File: rtl/spike_thermo_ctrl.sv
module spike_thermo_ctrl
  import stc_pkg::*;
#(
  parameter int STAGES = 5,
  localparam int EN_W  = STAGES - 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            spikeIn,
  input  logic            decMode,
  input  logic            loadEn,
  input  logic [EN_W-1:0] loadValue,
  output logic [EN_W-1:0] enable,
  output logic [EN_W-1:0] enableN,
  output logic            cellResetReq
);
  stcStrobes_t strobes;
  logic eventPulse;
  logic topStage;

  stc_spike_sync #(.SYNC_DEPTH(2)) uSync (
    .clk(clk), .rst(rst), .spikeIn(spikeIn), .eventPulse(eventPulse));

  stc_control uCtrl (
    .clk(clk), .rst(rst), .eventPulse(eventPulse), .loadEn(loadEn),
    .decMode(decMode), .topStage(topStage), .strobes(strobes),
    .cellResetReq(cellResetReq));

  stc_datapath #(.STAGES(STAGES)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .loadValue(loadValue),
    .enable(enable), .topStage(topStage));

  assign enableN = ~enable;

  // R5: complement output tracks the enables
  a_r5_complement: assert property (@(posedge clk) disable iff (rst)
    (enable ^ enableN) == '1);
endmodule

// File: tb/spike_thermo_ctrl_test.sv
module spike_thermo_ctrl_test;
  localparam int STAGES = 5;
  localparam int EN_W   = STAGES - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spikeIn = 1'b0;
  logic decMode = 1'b0;
  logic loadEn = 1'b0;
  logic [EN_W-1:0] loadValue = '0;
  logic [EN_W-1:0] enable, enableN;
  logic cellResetReq;

  int errors = 0;
  int checks = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  spike_thermo_ctrl #(.STAGES(STAGES)) uut (
    .clk(clk), .rst(rst), .spikeIn(spikeIn), .decMode(decMode),
    .loadEn(loadEn), .loadValue(loadValue), .enable(enable),
    .enableN(enableN), .cellResetReq(cellResetReq));

  // behavioural reference: level count plus a history of spike samples
  int lvl = 0;
  bit expReq = 0;
  bit hist[$] = '{0, 0, 0};
  int reqCycles = 0;

  function automatic int runOnes(logic [EN_W-1:0] v);
    int n = 0;
    for (int i = 0; i < EN_W; i++) begin
      if (v[i] && n == i) n++;
    end
    return n;
  endfunction

  function automatic logic [EN_W-1:0] thermo(int n);
    logic [EN_W-1:0] r = '0;
    for (int i = 0; i < EN_W; i++) r[i] = (i < n);
    return r;
  endfunction

  always @(posedge clk) begin
    bit ev;
    ev = hist[1] && !hist[2];
    if (rst) begin
      lvl = 0; expReq = 0;
      hist = '{0, 0, 0};
    end else begin
      hist.push_front(spikeIn);
      void'(hist.pop_back());
      if (lvl == STAGES) begin
        lvl = 0; expReq = 1;
      end else begin
        expReq = 0;
        if (loadEn) lvl = runOnes(loadValue);
        else if (ev) begin
          if (!decMode) lvl++;
          else if (lvl > 0) lvl--;
        end
      end
    end
  end

  task automatic check(string req, logic [EN_W:0] act, logic [EN_W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [EN_W-1:0] e;
    e = thermo(lvl > EN_W ? EN_W : lvl);
    if (!rst) begin
      check(curReq, {1'b0, enable}, {1'b0, e});
      check("R5", {1'b0, enableN}, {1'b0, ~e});
      check("R4", {EN_W'(0), cellResetReq}, {EN_W'(0), expReq});
      check("R9", {EN_W'(0), (enable & (enable + 1'b1)) == '0}, {EN_W'(0), 1'b1});
    end
    if (cellResetReq) reqCycles++;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic spike(int len, int gap);
    @(negedge clk); spikeIn = 1'b1;
    waitCyc(len);   spikeIn = 1'b0;
    waitCyc(gap);
  endtask

  task automatic load(logic [EN_W-1:0] v);
    @(negedge clk); loadEn = 1'b1; loadValue = v;
    @(negedge clk); loadEn = 1'b0;
  endtask

  initial begin
    waitCyc(3);
    // R1: reset state
    check("R1", {1'b0, enable}, '0);
    check("R1", {1'b0, enableN}, {1'b0, {EN_W{1'b1}}});
    check("R1", {EN_W'(0), cellResetReq}, '0);
    check("R10", ($bits(enable) == STAGES - 1 && $bits(enableN) == STAGES - 1) ? 1 : 0, 1);
    @(negedge clk); rst = 1'b0;

    curReq = "R3";
    for (int k = 0; k < EN_W; k++) spike(2, 4);
    check("R3", {1'b0, enable}, {1'b0, {EN_W{1'b1}}});

    curReq = "R4";
    reqCycles = 0;
    spike(2, 6);
    check("R4", reqCycles, 1);
    check("R4", {1'b0, enable}, '0);

    curReq = "R2";
    spike(20, 5);
    check("R2", {1'b0, enable}, {1'b0, thermo(1)});

    curReq = "R6";
    load(4'b1011); waitCyc(1);
    check("R6", {1'b0, enable}, {1'b0, 4'b0011});
    load(4'b0110); waitCyc(1);
    check("R6", {1'b0, enable}, '0);
    load(4'b0111); waitCyc(1);
    check("R6", {1'b0, enable}, {1'b0, 4'b0111});

    // R7: event lands on the same edge as a load, load wins
    curReq = "R7";
    @(negedge clk); spikeIn = 1'b1;
    @(negedge clk);
    @(negedge clk); loadEn = 1'b1; loadValue = 4'b0001;
    @(negedge clk); loadEn = 1'b0; spikeIn = 1'b0;
    waitCyc(4);
    check("R7", {1'b0, enable}, {1'b0, 4'b0001});
    // R7: reset beats a load
    @(negedge clk); rst = 1'b1; loadEn = 1'b1; loadValue = 4'b1111;
    @(negedge clk); rst = 1'b0; loadEn = 1'b0;
    check("R7", {1'b0, enable}, '0);

    curReq = "R8";
    load(4'b0111);
    decMode = 1'b1;
    reqCycles = 0;
    for (int k = 0; k < 4; k++) spike(3, 4);
    check("R8", {1'b0, enable}, '0);
    check("R8", reqCycles, 0);
    decMode = 1'b0;

    curReq = "R3";
    for (int k = 0; k < 2; k++) spike(1, 4);
    check("R3", {1'b0, enable}, {1'b0, 4'b0011});
    waitCyc(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule